// File: doc/BRIEF.md
# CAN Fault Confinement and Error-Event Flags

This block keeps the fault-confinement bookkeeping for one CAN node. Bit-level logic around it reports transmit errors, receive errors, good frames and sampled bus levels. From these the block maintains the transmit error count (TEC) and the receive error count (REC), and decides whether the node is error active, error passive, bus-off or halted. While the node is bus-off it counts runs of recessive bits until recovery is complete.

It also keeps three sticky event flags for an interrupt controller: overload seen, bus-off event, and entry into error passive. Software clears a flag by writing a one to its bit. Because a flag only records that an event happened, the live error state is available on its own output and is not affected by clearing a flag.

Top module: `can_fault_flags`

## Requirements
- R1: A `tx_err` pulse adds 8 to TEC. An `rx_err` pulse adds 1 to REC, which saturates at 255. A `frame_ok` pulse subtracts 1 from each counter, and neither counter goes below 0. If an error and `frame_ok` arrive in the same cycle, the error is applied to that counter. Counting happens only in the active or passive state, and only while `halt_req` is low. Each update appears one cycle after the pulse.
- R2: `state_o` encodes active as 0, passive as 1, bus-off as 2 and halt as 3. The node is passive outside bus-off and halt when TEC >= 128, REC >= 128, or `force_passive` was high in the previous cycle. Otherwise it is active. Reset gives active with both counts at 0 and all flags at 0.
- R3: When an update would bring TEC to 256 or more, TEC holds at 256 and the state becomes bus-off. TEC and REC stay frozen while the node is bus-off.
- R4: In bus-off, each `bit_stb` with `rx_recessive` high extends a run of recessive bits. A dominant bit restarts the current run but keeps the count of runs already completed. The 128th completed run of 11 recessive bits ends recovery: both counters clear to 0 and the state is classified again as in R2.
- R5: `halt_req` moves the node to halt from any state. From bus-off, `auto_halt_en` does the same. The node leaves halt when both inputs are low, and on leaving it clears both counters and is classified as in R2.
- R6: Flag bit 0 sets when `ovl_det` is high, even when `listen_only` is high. `ovl_frame_req` is `ovl_det` and not `listen_only`, in the active or passive state only.
- R7: Flag bit 1 sets on entry into bus-off, on completion of recovery, and on a move from bus-off to halt. A halt entered from active or passive does not set it.
- R8: Flag bit 2 sets only in the cycle the state changes into passive, not while the node remains passive.
- R9: When `wr_en` is high, each 1 in `wr_data` clears the matching flag and each 0 leaves it unchanged. Clearing a flag never changes `state_o`. If a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | Strobe marking one sampled bit time |
| rx_recessive | input | 1 | Sampled bus level is recessive, qualified by `bit_stb` |
| tx_err | input | 1 | Transmit error pulse |
| rx_err | input | 1 | Receive error pulse |
| frame_ok | input | 1 | Successful frame pulse |
| ovl_det | input | 1 | Overload condition detected |
| listen_only | input | 1 | Node must not drive the bus |
| force_passive | input | 1 | Test control forcing error passive |
| halt_req | input | 1 | Request to hold the node in halt |
| auto_halt_en | input | 1 | Move to halt automatically on bus-off |
| wr_en | input | 1 | Flag clear write strobe |
| wr_data | input | 3 | Write-one-to-clear mask for the flags |
| state_o | output | 2 | Error state |
| tec_o | output | 9 | Transmit error count |
| rec_o | output | 8 | Receive error count |
| flags_o | output | 3 | Sticky flags: bit 0 overload, bit 1 bus-off, bit 2 passive |
| ovl_frame_req | output | 1 | Overload frame may be sent now |

## Verification
The bench targets several edges of the counters and the recovery logic. It drives TEC across 128 and 256, where an off-by-one threshold would change state one error early or late. It applies an error and `frame_ok` in the same cycle, where the wrong priority would leave the count 9 too low. It places a dominant bit after some recessive runs have already completed. A design that also reset the count of completed runs would stay in bus-off far too long, and one that ignored the dominant bit would recover early. It also sets and clears a flag in the same cycle, writes zeros, and clears the bus-off flag while the node is still bus-off. A design that got these wrong would drop an event or disturb the live state.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'b00,
    ST_PASSIVE = 2'b01,
    ST_BUSOFF  = 2'b10,
    ST_HALT    = 2'b11
  } fc_state_e;

  localparam int FL_OVL  = 0;
  localparam int FL_BOFF = 1;
  localparam int FL_PASS = 2;
  localparam int FL_W    = 3;

  // Active or passive outside bus-off and halt.
  function automatic fc_state_e classify(input int tec, input int rec,
                                         input logic force_p, input int lim);
    return (tec >= lim || rec >= lim || force_p) ? ST_PASSIVE : ST_ACTIVE;
  endfunction

  function automatic int add_sat(input int v, input int inc, input int cap);
    return (v + inc > cap) ? cap : v + inc;
  endfunction

  function automatic int dec_floor(input int v);
    return (v > 0) ? v - 1 : 0;
  endfunction

endpackage

// File: rtl/can_fc_counters.sv
module can_fc_counters import can_fc_pkg::*; #(
  parameter int TEC_W      = 9,
  parameter int REC_W      = 8,
  parameter int BUSOFF_LIM = 256,
  parameter int REC_CAP    = 255,
  parameter int TX_INC     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic             tx_err,
  input  logic             rx_err,
  input  logic             frame_ok,
  output logic [TEC_W-1:0] tec_q,
  output logic [REC_W-1:0] rec_q,
  output logic [TEC_W-1:0] tec_n,
  output logic [REC_W-1:0] rec_n
);

  always_comb begin
    tec_n = tec_q;
    rec_n = rec_q;
    if (clr) begin
      tec_n = '0;
      rec_n = '0;
    end else if (en) begin
      if (tx_err)
        tec_n = TEC_W'(add_sat(int'(tec_q), TX_INC, BUSOFF_LIM));
      else if (frame_ok)
        tec_n = TEC_W'(dec_floor(int'(tec_q)));
      if (rx_err)
        rec_n = REC_W'(add_sat(int'(rec_q), 1, REC_CAP));
      else if (frame_ok)
        rec_n = REC_W'(dec_floor(int'(rec_q)));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tec_q <= '0;
      rec_q <= '0;
    end else begin
      tec_q <= tec_n;
      rec_q <= rec_n;
    end
  end

endmodule

// File: rtl/can_fc_recovery.sv
module can_fc_recovery #(
  parameter int RUN_LEN = 11,
  parameter int SEQ_LEN = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bit_stb,
  input  logic recessive,
  output logic done
);

  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam int SEQ_W = $clog2(SEQ_LEN + 1);

  logic [RUN_W-1:0] run_q;
  logic [SEQ_W-1:0] seq_q;
  logic             run_last;
  logic             seq_last;

  assign run_last = (run_q == RUN_W'(RUN_LEN - 1));
  assign seq_last = (seq_q == SEQ_W'(SEQ_LEN - 1));
  assign done     = en && bit_stb && recessive && run_last && seq_last;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      run_q <= '0;
      seq_q <= '0;
    end else if (bit_stb) begin
      if (!recessive) begin
        run_q <= '0;                       // dominant bit restarts the run only
      end else if (run_last) begin
        run_q <= '0;
        seq_q <= seq_last ? '0 : seq_q + 1'b1;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/can_fc_flags.sv
module can_fc_flags #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] flags_q
);

  for (genvar i = 0; i < W; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)
        flags_q[i] <= 1'b0;
      else if (set[i])
        flags_q[i] <= 1'b1;               // set has priority over clear
      else if (wr_en && wr_data[i])
        flags_q[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/can_fault_flags.sv
module can_fault_flags import can_fc_pkg::*; #(
  parameter int BUSOFF_LIM  = 256,
  parameter int PASSIVE_LIM = 128,
  parameter int REC_CAP     = 255,
  parameter int TX_INC      = 8,
  parameter int RUN_LEN     = 11,
  parameter int SEQ_LEN     = 128,
  parameter int TEC_W       = $clog2(BUSOFF_LIM) + 1,
  parameter int REC_W       = $clog2(REC_CAP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             rx_recessive,
  input  logic             tx_err,
  input  logic             rx_err,
  input  logic             frame_ok,
  input  logic             ovl_det,
  input  logic             listen_only,
  input  logic             force_passive,
  input  logic             halt_req,
  input  logic             auto_halt_en,
  input  logic             wr_en,
  input  logic [FL_W-1:0]  wr_data,
  output logic [1:0]       state_o,
  output logic [TEC_W-1:0] tec_o,
  output logic [REC_W-1:0] rec_o,
  output logic [FL_W-1:0]  flags_o,
  output logic             ovl_frame_req
);

  localparam logic [TEC_W-1:0] TEC_LIM = TEC_W'(BUSOFF_LIM);

  fc_state_e        state_q, state_n;
  logic [TEC_W-1:0] tec_n;
  logic [REC_W-1:0] rec_n;
  logic             on_bus, count_en, halt_hold, halt_release;
  logic             rec_done, cnt_clr;
  logic             ev_boff, ev_pass, ev_ovl;
  logic [FL_W-1:0]  ev_set;

  assign on_bus       = (state_q == ST_ACTIVE) || (state_q == ST_PASSIVE);
  assign count_en     = on_bus && !halt_req;
  assign halt_hold    = halt_req || auto_halt_en;
  assign halt_release = (state_q == ST_HALT) && !halt_hold;
  assign cnt_clr      = halt_release || (rec_done && !halt_hold);

  can_fc_counters #(
    .TEC_W(TEC_W), .REC_W(REC_W), .BUSOFF_LIM(BUSOFF_LIM),
    .REC_CAP(REC_CAP), .TX_INC(TX_INC)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(count_en), .clr(cnt_clr),
    .tx_err(tx_err), .rx_err(rx_err), .frame_ok(frame_ok),
    .tec_q(tec_o), .rec_q(rec_o), .tec_n(tec_n), .rec_n(rec_n)
  );

  can_fc_recovery #(.RUN_LEN(RUN_LEN), .SEQ_LEN(SEQ_LEN)) u_rcv (
    .clk(clk), .rst_n(rst_n), .en(state_q == ST_BUSOFF),
    .bit_stb(bit_stb), .recessive(rx_recessive), .done(rec_done)
  );

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_ACTIVE, ST_PASSIVE: begin
        if (halt_req)             state_n = ST_HALT;
        else if (tec_n >= TEC_LIM) state_n = ST_BUSOFF;
        else state_n = classify(int'(tec_n), int'(rec_n), force_passive, PASSIVE_LIM);
      end
      ST_BUSOFF: begin
        if (halt_hold)     state_n = ST_HALT;
        else if (rec_done) state_n = classify(0, 0, force_passive, PASSIVE_LIM);
      end
      ST_HALT: begin
        if (!halt_hold)    state_n = classify(0, 0, force_passive, PASSIVE_LIM);
      end
      default: state_n = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_ACTIVE;
    else        state_q <= state_n;
  end

  // Named events for the flags and the checker.
  assign ev_boff = ((state_n == ST_BUSOFF) && (state_q != ST_BUSOFF))
                || ((state_q == ST_BUSOFF) && (state_n != ST_BUSOFF));
  assign ev_pass = (state_n == ST_PASSIVE) && (state_q != ST_PASSIVE);
  assign ev_ovl  = ovl_det;

  always_comb begin
    ev_set          = '0;
    ev_set[FL_OVL]  = ev_ovl;
    ev_set[FL_BOFF] = ev_boff;
    ev_set[FL_PASS] = ev_pass;
  end

  can_fc_flags #(.W(FL_W)) u_flg (
    .clk(clk), .rst_n(rst_n), .set(ev_set),
    .wr_en(wr_en), .wr_data(wr_data), .flags_q(flags_o)
  );

  assign state_o       = state_q;
  assign ovl_frame_req = ovl_det && !listen_only && on_bus;

endmodule

// File: rtl/can_fc_checker.sv
module can_fc_checker import can_fc_pkg::*; #(
  parameter int TEC_W       = 9,
  parameter int REC_W       = 8,
  parameter int BUSOFF_LIM  = 256,
  parameter int PASSIVE_LIM = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       state_o,
  input logic [TEC_W-1:0] tec_o,
  input logic [REC_W-1:0] rec_o,
  input logic [FL_W-1:0]  flags_o,
  input logic             wr_en,
  input logic [FL_W-1:0]  wr_data,
  input logic             force_passive,
  input logic             ev_boff,
  input logic             ev_ovl
);

  localparam logic [TEC_W-1:0] TCAP = TEC_W'(BUSOFF_LIM);
  localparam logic [TEC_W-1:0] TPAS = TEC_W'(PASSIVE_LIM);
  localparam logic [REC_W-1:0] RPAS = REC_W'(PASSIVE_LIM);

  logic [FL_W-1:0] keep;
  assign keep = flags_o & ~(wr_en ? wr_data : '0);

  a_r3_tec_cap: assert property (@(posedge clk) disable iff (!rst_n)
    tec_o <= TCAP);

  a_r3_frozen_busoff: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 2'b10 |=> (state_o != 2'b10) || ($stable(tec_o) && $stable(rec_o)));

  a_r2_passive_cause: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (state_o != 2'b01) || tec_o >= TPAS || rec_o >= RPAS || $past(force_passive));

  a_r7_boff_entry_flag: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'b10 |=> (state_o != 2'b10) || flags_o[FL_BOFF]);

  a_r7_boff_event_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_boff |=> flags_o[FL_BOFF]);

  a_r8_pass_entry_flag: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'b01 |=> (state_o != 2'b01) || flags_o[FL_PASS]);

  a_r6_ovl_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovl |=> flags_o[FL_OVL]);

  a_r9_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_o & $past(keep)) == $past(keep)));

endmodule

bind can_fault_flags can_fc_checker #(
  .TEC_W(TEC_W), .REC_W(REC_W), .BUSOFF_LIM(BUSOFF_LIM), .PASSIVE_LIM(PASSIVE_LIM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .state_o(state_o), .tec_o(tec_o), .rec_o(rec_o),
  .flags_o(flags_o), .wr_en(wr_en), .wr_data(wr_data),
  .force_passive(force_passive), .ev_boff(ev_boff), .ev_ovl(ev_ovl)
);

// File: tb/test_can_fault_flags.sv
module test_can_fault_flags;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_stb = 0, rx_recessive = 0, tx_err = 0, rx_err = 0, frame_ok = 0;
  logic ovl_det = 0, listen_only = 0, force_passive = 0, halt_req = 0, auto_halt_en = 0;
  logic wr_en = 0;
  logic [2:0] wr_data = '0;
  logic [1:0] state_o;
  logic [8:0] tec_o;
  logic [7:0] rec_o;
  logic [2:0] flags_o;
  logic       ovl_frame_req;

  int checks = 0, failures = 0;
  bit finished = 0;

  // reference model state
  int m_state = 0, m_tec = 0, m_rec = 0, m_run = 0, m_seq = 0;
  bit [2:0] m_flags = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_fault_flags i_can_fault_flags (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_recessive(rx_recessive),
    .tx_err(tx_err), .rx_err(rx_err), .frame_ok(frame_ok), .ovl_det(ovl_det),
    .listen_only(listen_only), .force_passive(force_passive), .halt_req(halt_req),
    .auto_halt_en(auto_halt_en), .wr_en(wr_en), .wr_data(wr_data),
    .state_o(state_o), .tec_o(tec_o), .rec_o(rec_o), .flags_o(flags_o),
    .ovl_frame_req(ovl_frame_req)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pick(int tec, int rec, bit f);
    return (tec >= 128 || rec >= 128 || f) ? 1 : 0;
  endfunction

  task automatic model_edge();
    int nt, nr, ns;
    bit [2:0] ev;
    bit done;
    nt = m_tec; nr = m_rec; ns = m_state; ev = '0; done = 0;
    if (!rst_n) begin
      m_state = 0; m_tec = 0; m_rec = 0; m_run = 0; m_seq = 0; m_flags = '0;
      return;
    end
    if (m_state <= 1) begin
      if (!halt_req) begin
        if (tx_err) nt = (m_tec + 8 > 256) ? 256 : m_tec + 8;
        else if (frame_ok && m_tec > 0) nt = m_tec - 1;
        if (rx_err) nr = (m_rec == 255) ? 255 : m_rec + 1;
        else if (frame_ok && m_rec > 0) nr = m_rec - 1;
      end
      if (halt_req) ns = 3;
      else if (nt >= 256) ns = 2;
      else ns = pick(nt, nr, force_passive);
    end else if (m_state == 2) begin
      done = bit_stb && rx_recessive && m_run == 10 && m_seq == 127;
      if (halt_req || auto_halt_en) ns = 3;
      else if (done) begin nt = 0; nr = 0; ns = pick(0, 0, force_passive); end
    end else begin
      if (!halt_req && !auto_halt_en) begin nt = 0; nr = 0; ns = pick(0, 0, force_passive); end
    end
    // recovery counting
    if (m_state != 2) begin m_run = 0; m_seq = 0; end
    else if (bit_stb) begin
      if (!rx_recessive) m_run = 0;
      else if (m_run == 10) begin m_run = 0; m_seq = (m_seq == 127) ? 0 : m_seq + 1; end
      else m_run++;
    end
    ev[0] = ovl_det;
    ev[1] = (ns == 2) != (m_state == 2);
    ev[2] = (ns == 1) && (m_state != 1);
    m_flags = (m_flags & ~(wr_en ? wr_data : 3'b000)) | ev;
    m_state = ns; m_tec = nt; m_rec = nr;
  endtask

  task automatic compare();
    chk("R2 state", int'(state_o), m_state);
    chk("R1 tec", int'(tec_o), m_tec);
    chk("R1 rec", int'(rec_o), m_rec);
    chk("R9 flags", int'(flags_o), int'(m_flags));
    chk("R6 ovl_frame_req", int'(ovl_frame_req),
        int'(ovl_det && !listen_only && m_state <= 1));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic clear_pulses();
    tx_err = 0; rx_err = 0; frame_ok = 0; ovl_det = 0; bit_stb = 0;
    wr_en = 0; wr_data = '0;
  endtask

  task automatic pulse_tx(int n);
    for (int i = 0; i < n; i++) begin tx_err = 1; step(); tx_err = 0; end
  endtask
  task automatic pulse_rx(int n);
    for (int i = 0; i < n; i++) begin rx_err = 1; step(); rx_err = 0; end
  endtask
  task automatic pulse_ok(int n);
    for (int i = 0; i < n; i++) begin frame_ok = 1; step(); frame_ok = 0; end
  endtask
  task automatic bits(int n, bit lvl);
    for (int i = 0; i < n; i++) begin bit_stb = 1; rx_recessive = lvl; step(); end
    bit_stb = 0; rx_recessive = 0;
  endtask
  task automatic w1c(bit [2:0] m);
    wr_en = 1; wr_data = m; step(); wr_en = 0; wr_data = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2: reset values
    chk("R2 reset state", int'(state_o), 0);
    chk("R2 reset tec", int'(tec_o), 0);
    chk("R9 reset flags", int'(flags_o), 0);
    rst_n = 1;

    // R1: increments, decrement, same-cycle priority
    pulse_tx(3);
    chk("R1 tec after 3 tx", int'(tec_o), 24);
    pulse_rx(5);
    pulse_ok(1);
    chk("R1 tec after ok", int'(tec_o), 23);
    chk("R1 rec after ok", int'(rec_o), 4);
    tx_err = 1; frame_ok = 1; step(); clear_pulses();
    chk("R1 error beats ok", int'(tec_o), 31);
    pulse_ok(40);
    chk("R1 floor tec", int'(tec_o), 0);
    chk("R1 floor rec", int'(rec_o), 0);

    // R2/R8: passive by REC threshold, flag only on entry
    pulse_rx(127);
    chk("R2 still active at 127", int'(state_o), 0);
    pulse_rx(1);
    chk("R2 passive at 128", int'(state_o), 1);
    chk("R8 passive flag", int'(flags_o[2]), 1);
    w1c(3'b100);
    pulse_rx(3);
    chk("R8 no re-set while passive", int'(flags_o[2]), 0);
    pulse_ok(4);
    chk("R2 back to active", int'(state_o), 0);
    force_passive = 1; step(); step();
    chk("R2 forced passive", int'(state_o), 1);
    chk("R8 flag on forced entry", int'(flags_o[2]), 1);
    force_passive = 0; step();
    pulse_ok(130);

    // R9: write zero, write one, set wins
    w1c(3'b000);
    chk("R9 zero write keeps", int'(flags_o[2]), 1);
    w1c(3'b100);
    chk("R9 one write clears", int'(flags_o[2]), 0);
    ovl_det = 1; wr_en = 1; wr_data = 3'b001; step(); clear_pulses();
    chk("R9 set beats clear", int'(flags_o[0]), 1);

    // R6: overload under listen-only
    listen_only = 1; ovl_det = 1;
    #1 chk("R6 no frame in listen-only", int'(ovl_frame_req), 0);
    step(); ovl_det = 0; listen_only = 0;
    chk("R6 flag set in listen-only", int'(flags_o[0]), 1);
    w1c(3'b111);

    // R3/R7: bus-off entry
    pulse_tx(31);
    chk("R3 below limit", int'(state_o), 1);
    pulse_tx(1);
    chk("R3 bus-off", int'(state_o), 2);
    chk("R3 tec held", int'(tec_o), 256);
    chk("R7 entry flag", int'(flags_o[1]), 1);
    pulse_tx(2); pulse_ok(2);
    chk("R3 frozen", int'(tec_o), 256);
    w1c(3'b010);
    chk("R9 cleared in bus-off", int'(flags_o[1]), 0);
    chk("R9 state kept", int'(state_o), 2);

    // R4: recovery with an interrupted run
    bits(11, 1); bits(4, 1); bits(1, 0);
    bits(11 * 127 - 1, 1);
    chk("R4 one bit short", int'(state_o), 2);
    bits(1, 1);
    chk("R4 recovered", int'(state_o), 0);
    chk("R4 tec cleared", int'(tec_o), 0);
    chk("R7 recovery flag", int'(flags_o[1]), 1);
    w1c(3'b111);

    // R5/R7: halt from active does not flag
    pulse_tx(4);
    halt_req = 1; step(); step();
    chk("R5 halt", int'(state_o), 3);
    chk("R7 no flag from active", int'(flags_o[1]), 0);
    halt_req = 0; step();
    chk("R5 release", int'(state_o), 0);
    chk("R5 release clears", int'(tec_o), 0);

    // R5/R7: automatic halt from bus-off
    pulse_tx(32);
    w1c(3'b111);
    auto_halt_en = 1; step();
    chk("R5 auto halt", int'(state_o), 3);
    chk("R7 halt flag", int'(flags_o[1]), 1);
    auto_halt_en = 0; step();
    chk("R5 exit auto halt", int'(state_o), 0);
    step();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule